// File: doc/BRIEF.md
# Mode-3 SPI Slave with Transmit and Receive Queues

This block is the slave side of an SPI link with a short byte queue in each direction. An on-chip controller uses a byte-wide register port. It queues outgoing bytes before a frame or while a frame is running, and it collects incoming bytes whenever it has time. The SPI pins are brought into the system clock domain through flop synchronisers. The system clock must therefore run at least eight times faster than the serial clock.

A frame lasts as long as the active-low select stays low, and it may hold any number of bytes. A new outgoing byte is taken from the transmit queue when the master starts the byte. If the queue is empty at that moment, the slave records a transmit underflow and fills the slot with a stand-in byte: either 0x00 or a repeat of the previous byte, chosen by a configuration bit. Bytes queued after an underflow go out at the next byte boundary, so none are lost and none are delayed. A received byte that finds the receive queue full is dropped, and a sticky overflow flag is set.

Register map (`reg_addr`): 0 = data (a write queues a transmit byte, a read pops the oldest received byte, or returns 0x00 when the queue is empty); 1 = status (read only); 2 = configuration (bit 0 = zero-fill enable, reset value 1).

Top module: `spi_fifo_slave`

## Requirements
- R1: Serial mode 3 with MSB first. `spi_miso` changes after falling edges of `spi_sclk`, `spi_mosi` is captured on rising edges, and bit 7 is the first bit of each byte.
- R2: The transmit queue holds 4 bytes. Status bits [2:0] give its level, 0 to 4. A data write made while the level is 4 is discarded.
- R3: Bytes queued before select goes low are sent first in the frame, in the order they were written.
- R4: One frame carries several consecutive bytes in each direction.
- R5: When a byte starts and the transmit queue is empty, status bit 6 (underflow) is set. If configuration bit 0 is 1, the byte sent is 0x00.
- R6: If configuration bit 0 is 0, an underflowed byte slot repeats the byte sent just before it.
- R7: A byte queued after an underflow, in the middle of a frame, is sent as the next byte, and no queued byte is lost.
- R8: The receive queue holds 4 bytes. Status bits [5:3] give its level. Data reads return the received bytes oldest first.
- R9: When a byte completes while the receive queue is full, status bit 7 (overflow) is set, the new byte is discarded, and the stored bytes are kept.
- R10: Status bits 6 and 7 are sticky and are cleared by a status read. The level fields are not changed by that read.
- R11: If select rises in the middle of a byte, the partial byte is discarded. The next frame starts again at bit 7.
- R12: After reset, status reads 0x00, configuration reads 0x01 and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idles high |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when not selected |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clocks the side effects of a read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |

## Verification
The bench goes after the underflow corner cases. A frame outruns its two queued bytes, which must produce zero bytes. With zero-fill off, the slot must repeat the previous byte. A byte pushed into the queue in the middle of a frame after an underflow must appear in the very next slot; a design that latched into an error state would drop it or shift it back one slot. Writing a fifth transmit byte and pushing a fifth received byte check that a full queue neither takes the new byte nor corrupts the stored ones. Clearing on a status read must leave the level fields alone. A select that rises after three bits checks that no partial byte reaches the receive queue and that the next frame is aligned to bit 7.

// File: rtl/spi_fifo_slave_pkg.sv
`timescale 1ns/1ps
package spi_fifo_slave_pkg;
   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_CFG  = 2'd2;

   localparam int STAT_TXLVL_LSB = 0;
   localparam int STAT_RXLVL_LSB = 3;
   localparam int STAT_UF_BIT    = 6;
   localparam int STAT_OV_BIT    = 7;
   localparam int LVL_FIELD_W    = 3;
endpackage

// File: rtl/spi_slv_sync.sv
`timescale 1ns/1ps
module spi_slv_sync #(
   parameter int               WIDTH     = 3,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("spi_slv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RESET_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_fifo.sv
`timescale 1ns/1ps
module spi_slv_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             push_ok, pop_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/spi_slv_engine.sv
`timescale 1ns/1ps
module spi_slv_engine #(
   parameter int W = 8,
   localparam int CNT_W = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclk_s,
   input  logic         mosi_s,
   input  logic         ss_n_s,
   input  logic         zero_en,
   input  logic         tx_empty,
   input  logic [W-1:0] tx_head,
   output logic         tx_pop,
   output logic         uf_evt,
   output logic         rx_push,
   output logic [W-1:0] rx_byte,
   output logic         miso
);
   logic             sclk_d, sel, fall, rise, byte_start;
   logic [CNT_W-1:0] bit_cnt;
   logic [W-1:0]     sh_out, last_tx, load_byte;
   logic [W-2:0]     sh_in;

   assign sel        = !ss_n_s;
   assign fall       = sel && sclk_d && !sclk_s;
   assign rise       = sel && !sclk_d && sclk_s;
   assign byte_start = fall && (bit_cnt == '0);

   assign load_byte = !tx_empty ? tx_head : (zero_en ? '0 : last_tx);
   assign tx_pop    = byte_start && !tx_empty;
   assign uf_evt    = byte_start && tx_empty;
   assign rx_byte   = {sh_in, mosi_s};
   assign rx_push   = rise && (bit_cnt == CNT_W'(W - 1));
   assign miso      = sel && sh_out[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b1;
         bit_cnt <= '0;
         sh_out  <= '0;
         sh_in   <= '0;
         last_tx <= '0;
      end else begin
         sclk_d <= sclk_s;
         if (!sel) begin
            bit_cnt <= '0;
            sh_out  <= '0;
         end else begin
            if (byte_start) begin
               sh_out  <= load_byte;
               last_tx <= load_byte;
            end else if (fall) begin
               sh_out <= {sh_out[W-2:0], 1'b0};
            end
            if (rise) begin
               sh_in   <= rx_byte[W-2:0];
               bit_cnt <= (bit_cnt == CNT_W'(W - 1)) ? '0 : bit_cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/spi_fifo_slave.sv
`timescale 1ns/1ps
module spi_fifo_slave
   import spi_fifo_slave_pkg::*;
#(
   parameter int   FIFO_DEPTH  = 4,
   parameter int   SYNC_STAGES = 2,
   parameter logic ZEN_RESET   = 1'b1,
   localparam int  DW    = 8,
   localparam int  LVL_W = $clog2(FIFO_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spi_sclk,
   input  logic          spi_ss_n,
   input  logic          spi_mosi,
   output logic          spi_miso,
   input  logic [1:0]    reg_addr,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata
);
   generate
      if (FIFO_DEPTH < 2 || FIFO_DEPTH > 7) begin : g_bad_depth
         $error("spi_fifo_slave: FIFO_DEPTH must lie in 2..7 to fit the status fields");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       ss_n_s, sclk_s, mosi_s;

   spi_slv_sync #(
      .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b110)
   ) sync_i (
      .clk(clk), .rst_n(rst_n),
      .d({spi_ss_n, spi_sclk, spi_mosi}),
      .q(pins_s)
   );
   assign {ss_n_s, sclk_s, mosi_s} = pins_s;

   logic             zero_en, uf_q, ov_q;
   logic             tx_push, tx_pop, tx_full, tx_empty;
   logic             rx_push, rx_pop, rx_full, rx_empty;
   logic             uf_evt, stat_rd;
   logic [DW-1:0]    tx_head, rx_head, rx_byte, status;
   logic [LVL_W-1:0] tx_level, rx_level;

   assign tx_push = reg_wr && (reg_addr == ADDR_DATA);
   assign rx_pop  = reg_rd && (reg_addr == ADDR_DATA);
   assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

   spi_slv_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .push_data(reg_wdata), .pop(tx_pop),
      .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
   );

   spi_slv_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .push_data(rx_byte), .pop(rx_pop),
      .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
   );

   spi_slv_engine #(.W(DW)) engine_i (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(sclk_s), .mosi_s(mosi_s), .ss_n_s(ss_n_s),
      .zero_en(zero_en), .tx_empty(tx_empty), .tx_head(tx_head),
      .tx_pop(tx_pop), .uf_evt(uf_evt),
      .rx_push(rx_push), .rx_byte(rx_byte), .miso(spi_miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_en <= ZEN_RESET;
         uf_q    <= 1'b0;
         ov_q    <= 1'b0;
      end else begin
         if (reg_wr && (reg_addr == ADDR_CFG)) zero_en <= reg_wdata[0];
         uf_q <= uf_evt | (uf_q & !stat_rd);
         ov_q <= (rx_push & rx_full) | (ov_q & !stat_rd);
      end
   end

   always_comb begin
      status = '0;
      status[STAT_TXLVL_LSB +: LVL_FIELD_W] = LVL_FIELD_W'(tx_level);
      status[STAT_RXLVL_LSB +: LVL_FIELD_W] = LVL_FIELD_W'(rx_level);
      status[STAT_UF_BIT] = uf_q;
      status[STAT_OV_BIT] = ov_q;
   end

   always_comb begin
      case (reg_addr)
         ADDR_DATA: reg_rdata = rx_empty ? '0 : rx_head;
         ADDR_STAT: reg_rdata = status;
         ADDR_CFG:  reg_rdata = {{(DW-1){1'b0}}, zero_en};
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_fifo_slave_chk.sv
`timescale 1ns/1ps
module spi_fifo_slave_chk #(
   parameter int DEPTH = 4,
   parameter int LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_push,
   input logic             tx_pop,
   input logic             tx_full,
   input logic [LVL_W-1:0] tx_level,
   input logic             rx_push,
   input logic             rx_pop,
   input logic             rx_full,
   input logic [LVL_W-1:0] rx_level,
   input logic             uf_evt,
   input logic             uf_q,
   input logic             ov_q,
   input logic             stat_rd,
   input logic             zero_en,
   input logic             spi_miso
);
   AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LVL_W'(DEPTH)); // R2
   AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && tx_full && !tx_pop) |=> (tx_level == LVL_W'(DEPTH))); // R2
   AST_UF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt |=> uf_q); // R5
   AST_UF_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_evt && zero_en) |=> !spi_miso); // R5
   AST_RX_OVERFLOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full && !rx_pop) |=> (ov_q && rx_level == LVL_W'(DEPTH))); // R9
   AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_q && !stat_rd) |=> uf_q); // R10
   AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q && !stat_rd) |=> ov_q); // R10
endmodule

bind spi_fifo_slave spi_fifo_slave_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full), .tx_level(tx_level),
   .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full), .rx_level(rx_level),
   .uf_evt(uf_evt), .uf_q(uf_q), .ov_q(ov_q), .stat_rd(stat_rd),
   .zero_en(zero_en), .spi_miso(spi_miso)
);

// File: tb/spi_fifo_slave_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_slave_tb_top;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sclk = 1'b1, spi_ss_n = 1'b1, spi_mosi = 1'b0;
   logic       spi_miso;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   spi_fifo_slave dut_i (
      .clk(clk), .rst_n(rst_n),
      .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic frame_open();
      spi_ss_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic frame_close();
      repeat (4) @(negedge clk);
      spi_ss_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic spi_bits(input int nbits, input logic [7:0] tx, output logic [7:0] rx);
      rx = 8'h00;
      for (int b = 7; b > 7 - nbits; b--) begin
         @(negedge clk);
         spi_sclk = 1'b0; spi_mosi = tx[b];
         repeat (HALF) @(negedge clk);
         rx[b] = spi_miso; spi_sclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
   endtask

   task automatic clear_flags();
      logic [7:0] d;
      reg_read(2'd1, d);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      reg_read(2'd1, d); check("R12 status", d, 8'h00);
      reg_read(2'd2, d); check("R12 config", d, 8'h01);
      check("R12 miso", {7'b0, spi_miso}, 8'h00);
   endtask

   task automatic t_tx_fill();
      logic [7:0] d;
      reg_write(2'd0, 8'hA5); reg_write(2'd0, 8'h0F);
      reg_write(2'd0, 8'hF0); reg_write(2'd0, 8'h96);
      reg_read(2'd1, d); check("R2 tx level full", d & 8'h07, 8'h04);
      reg_write(2'd0, 8'h77);
      reg_read(2'd1, d); check("R2 write when full dropped", d & 8'h07, 8'h04);
   endtask

   task automatic t_stream();
      logic [7:0] r, d;
      logic [7:0] mo [4] = '{8'h81, 8'h3C, 8'hE7, 8'h5A};
      logic [7:0] ex [4] = '{8'hA5, 8'h0F, 8'hF0, 8'h96};
      frame_open();
      for (int i = 0; i < 4; i++) begin
         spi_bits(8, mo[i], r);
         check("R3 R4 R1 miso byte in order", r, ex[i]);
      end
      frame_close();
      reg_read(2'd1, d);
      check("R8 rx level 4, tx level 0", d, 8'h20);
      for (int i = 0; i < 4; i++) begin
         reg_read(2'd0, d);
         check("R8 R1 rx byte oldest first", d, mo[i]);
      end
   endtask

   task automatic t_underflow_zero();
      logic [7:0] r, d;
      logic [7:0] ex [4] = '{8'h5A, 8'hC3, 8'h00, 8'h00};
      reg_write(2'd2, 8'h01);
      clear_flags();
      reg_write(2'd0, 8'h5A); reg_write(2'd0, 8'hC3);
      frame_open();
      for (int i = 0; i < 4; i++) begin
         spi_bits(8, 8'h00, r);
         check("R5 zero fill after queue empties", r, ex[i]);
      end
      frame_close();
      reg_read(2'd1, d);
      check("R5 underflow flag", d & 8'h40, 8'h40);
      reg_read(2'd1, d);
      check("R10 underflow cleared by read", d & 8'h40, 8'h00);
      for (int i = 0; i < 4; i++) reg_read(2'd0, d);
   endtask

   task automatic t_underflow_repeat();
      logic [7:0] r, d;
      reg_write(2'd2, 8'h00);
      clear_flags();
      reg_write(2'd0, 8'h7E);
      frame_open();
      for (int i = 0; i < 3; i++) begin
         spi_bits(8, 8'h00, r);
         check("R6 repeat last byte", r, 8'h7E);
      end
      frame_close();
      for (int i = 0; i < 3; i++) reg_read(2'd0, d);
      reg_write(2'd2, 8'h01);
   endtask

   task automatic t_refill_mid_frame();
      logic [7:0] r, d;
      clear_flags();
      frame_open();
      spi_bits(8, 8'h00, r);
      check("R5 empty queue gives zero", r, 8'h00);
      reg_write(2'd0, 8'h99);
      reg_write(2'd0, 8'h42);
      spi_bits(8, 8'h00, r);
      check("R7 queued byte after underflow", r, 8'h99);
      spi_bits(8, 8'h00, r);
      check("R7 following byte not lost", r, 8'h42);
      frame_close();
      for (int i = 0; i < 3; i++) reg_read(2'd0, d);
   endtask

   task automatic t_overflow();
      logic [7:0] r, d;
      clear_flags();
      frame_open();
      for (int i = 1; i <= 5; i++) spi_bits(8, 8'(i), r);
      frame_close();
      reg_read(2'd1, d);
      check("R9 overflow flag with rx level 4", d & 8'hB8, 8'hA0);
      reg_read(2'd1, d);
      check("R10 read keeps level, clears overflow", d & 8'hB8, 8'h20);
      for (int i = 1; i <= 4; i++) begin
         reg_read(2'd0, d);
         check("R9 stored bytes kept", d, 8'(i));
      end
   endtask

   task automatic t_abort();
      logic [7:0] r, d;
      clear_flags();
      frame_open();
      spi_bits(3, 8'hFF, r);
      spi_ss_n = 1'b1;
      repeat (10) @(negedge clk);
      reg_read(2'd1, d);
      check("R11 partial byte discarded", d & 8'h38, 8'h00);
      reg_write(2'd0, 8'hC9);
      frame_open();
      spi_bits(8, 8'hB6, r);
      check("R11 next frame sends from bit 7", r, 8'hC9);
      frame_close();
      reg_read(2'd0, d);
      check("R11 next frame receives from bit 7", d, 8'hB6);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_tx_fill();
      t_stream();
      t_underflow_zero();
      t_underflow_repeat();
      t_refill_mid_frame();
      t_overflow();
      t_abort();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule